// File: doc/BRIEF.md
# Per-Bit Attribute Control/Status Register

A single parameterised control/status register in which every bit has its own access behaviour, fixed at elaboration. The behaviour of bit `i` is a 4-bit code held in nibble `i` of the `ATTR` parameter. Separate mask parameters add a survive-normal-reset property, a key role, a lock and a one-shot write to chosen bits. Software reaches the register through a one-cycle port: select, read strobe, write strobe, write data and combinational read data. Hardware logic drives per-bit set, clear and load inputs and a lock input.

Read data reflects the stored state in the cycle the read strobe is high. Any change that a read causes, and every write, takes effect at the next rising clock edge. The load, clear and set inputs from hardware are applied after the software effects, in that order, so a hardware set always survives. There are two synchronous resets. `pg_rst_n` restores every bit. `rst_n` restores every bit except those marked in `STICKY`.

Top module: `attr_csr`

## Requirements
- R1: A read-only bit (code 0) ignores software writes. It takes `hw_val_i[i]` when `hw_upd_i[i]` is high.
- R2: A read/write bit (code 1) stores the written data bit and reads it back.
- R3: A clear-on-one bit (code 2) is set by `hw_set_i`. A written 1 clears it and a written 0 leaves it unchanged.
- R4: A clear-on-zero bit (code 3) is set by `hw_set_i`. A written 0 clears it and a written 1 leaves it unchanged.
- R5: A set-on-one bit (code 4) is set by a written 1, keeps its value on a written 0, and is cleared by `hw_clr_i`.
- R6: A write-only bit (code 5) and a reserved-zero bit (code 10) always read as 0.
- R7: A read-clear bit (code 6) and a read-clear/writable bit (code 8) return their value on a read and hold 0 from the next cycle. Code 8 also stores written data.
- R8: A read-sets bit (code 7) returns its value on a read and holds 1 from the next cycle. A written 1 clears it and a written 0 is ignored.
- R9: A constant bit (code 11) and a reserved-preserve bit (code 9) always read their `INIT` value, whatever software and hardware do.
- R10: Bits in `STICKY` keep their value through `rst_n` and return to `INIT` only on `pg_rst_n`. All other stored bits return to `INIT` on either reset.
- R11: A bit in `ONCE` accepts only the first software write after either reset and ignores later writes. `ONCE` has no effect on a bit that is also in `LOCK`.
- R12: A bit in `LOCK` ignores software writes while `lock_i` is high or any bit in `KEY` is 1. The key state is taken from before the current write.
- R13: When `hw_set_i[i]` is high, bit `i` is 1 in the next cycle, even if a software clear, a read clear or `hw_clr_i[i]` hits it in the same cycle.
- R14: `rdata_o` is zero whenever `sel_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Normal synchronous reset, active low |
| pg_rst_n | input | 1 | Power-good synchronous reset, active low, restores all bits |
| sel_i | input | 1 | Software access targets this register |
| rd_i | input | 1 | Software read strobe |
| wr_i | input | 1 | Software write strobe |
| wdata_i | input | W | Software write data |
| rdata_o | output | W | Read data, combinational, zero when not selected |
| hw_set_i | input | W | Per-bit hardware set |
| hw_clr_i | input | W | Per-bit hardware clear |
| hw_upd_i | input | W | Per-bit hardware load enable |
| hw_val_i | input | W | Per-bit hardware load value |
| lock_i | input | 1 | External lock for bits in LOCK |

## Verification
Every bit type is driven with a written 1, a written 0, a hardware set or clear, and back-to-back reads. Together these separate the clear-on-one, clear-on-zero and set-on-one types, and they show whether a read changes the returned value or only the following one. Each of the two resets is applied after stored bits are set, which shows which bits are sticky. A sequence of lock input, key write, locked write and key clear shows that the lock uses the key value from before the write. Same-cycle hardware set combined with a software or hardware clear checks the priority rule.

// File: rtl/attr_csr.sv
module attr_csr #(
  parameter int W = 32,
  parameter logic [4*W-1:0] ATTR = 128'h1111_1111_1111_1111_1121_BA98_7654_3210,
  parameter logic [W-1:0] INIT   = 32'h0000_0A00,
  parameter logic [W-1:0] STICKY = 32'h0000_3000,
  parameter logic [W-1:0] KEY    = 32'h0000_4000,
  parameter logic [W-1:0] LOCK   = 32'h0000_8000,
  parameter logic [W-1:0] ONCE   = 32'h0001_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pg_rst_n,
  input  logic         sel_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] hw_set_i,
  input  logic [W-1:0] hw_clr_i,
  input  logic [W-1:0] hw_upd_i,
  input  logic [W-1:0] hw_val_i,
  input  logic         lock_i
);
  localparam logic [3:0] T_RO = 4'd0, T_RW = 4'd1, T_W1C = 4'd2, T_W0C = 4'd3,
                         T_W1S = 4'd4, T_WO = 4'd5, T_RC = 4'd6, T_RSW1C = 4'd7,
                         T_RCW = 4'd8, T_RSVP = 4'd9, T_RSVZ = 4'd10, T_ROC = 4'd11;
  localparam logic [W-1:0] ONCE_EFF = ONCE & ~LOCK;

  function automatic logic [W-1:0] fixed_mask();
    logic [W-1:0] m;
    for (int k = 0; k < W; k++) begin
      m[k] = (ATTR[4*k +: 4] == T_ROC) || (ATTR[4*k +: 4] == T_RSVP) ||
             (ATTR[4*k +: 4] == T_RSVZ);
    end
    return m;
  endfunction
  localparam logic [W-1:0] FIX_M = fixed_mask();

  logic [W-1:0] q, used, rd_view;
  logic lock_on, sw_wr, sw_rd;

  assign sw_wr   = sel_i & wr_i;
  assign sw_rd   = sel_i & rd_i;
  assign lock_on = lock_i | (|(q & KEY));

  wire unused_fixed = ^((hw_set_i | hw_clr_i | hw_upd_i | hw_val_i | wdata_i) & FIX_M);

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [3:0] A = ATTR[4*i +: 4];
    localparam bit FIXED  = (A == T_ROC) || (A == T_RSVP) || (A == T_RSVZ);
    localparam bit HIDDEN = (A == T_WO) || (A == T_RSVZ);

    if (FIXED) begin : g_fix
      assign q[i] = (A == T_RSVZ) ? 1'b0 : INIT[i];
    end else begin : g_st
      logic r, nx, blk;
      assign blk = (LOCK[i] & lock_on) | (ONCE_EFF[i] & used[i]);
      always_comb begin
        nx = r;
        if (sw_rd) begin
          if (A == T_RC || A == T_RCW) nx = 1'b0;
          else if (A == T_RSW1C)       nx = 1'b1;
        end
        if (sw_wr && !blk) begin
          if (A == T_RW || A == T_RCW || A == T_WO)               nx = wdata_i[i];
          else if ((A == T_W1C || A == T_RSW1C) && wdata_i[i])    nx = 1'b0;
          else if (A == T_W0C && !wdata_i[i])                     nx = 1'b0;
          else if (A == T_W1S && wdata_i[i])                      nx = 1'b1;
        end
        if (hw_upd_i[i]) nx = hw_val_i[i];
        if (hw_clr_i[i]) nx = 1'b0;
        if (hw_set_i[i]) nx = 1'b1;
      end
      always_ff @(posedge clk) begin
        if (!pg_rst_n)  r <= INIT[i];
        else if (!rst_n) r <= STICKY[i] ? r : INIT[i];
        else            r <= nx;
      end
      assign q[i] = r;
    end

    if (ONCE_EFF[i] && !FIXED) begin : g_once
      logic u;
      always_ff @(posedge clk) begin
        if (!pg_rst_n || !rst_n) u <= 1'b0;
        else if (sw_wr)          u <= 1'b1;
      end
      assign used[i] = u;
    end else begin : g_free
      assign used[i] = 1'b0;
    end

    assign rd_view[i] = HIDDEN ? 1'b0 : q[i];
  end

  assign rdata_o = sel_i ? rd_view : '0;
endmodule

// File: rtl/attr_csr_chk.sv
module attr_csr_chk #(
  parameter int W = 32,
  parameter logic [4*W-1:0] ATTR = 128'h1111_1111_1111_1111_1121_BA98_7654_3210,
  parameter logic [W-1:0] INIT   = 32'h0000_0A00,
  parameter logic [W-1:0] STICKY = 32'h0000_3000,
  parameter logic [W-1:0] LOCK   = 32'h0000_8000,
  parameter logic [W-1:0] ONCE   = 32'h0001_0000
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pg_rst_n,
  input logic         sel_i,
  input logic         rd_i,
  input logic         wr_i,
  input logic [W-1:0] hw_set_i,
  input logic [W-1:0] hw_clr_i,
  input logic [W-1:0] hw_upd_i,
  input logic [W-1:0] rdata_o,
  input logic [W-1:0] q,
  input logic [W-1:0] used
);
  function automatic logic [W-1:0] mk(input logic [3:0] c);
    logic [W-1:0] m;
    for (int k = 0; k < W; k++) m[k] = (ATTR[4*k +: 4] == c);
    return m;
  endfunction
  localparam logic [W-1:0] M_RO = mk(4'd0), M_WO = mk(4'd5), M_RC = mk(4'd6),
                           M_RCW = mk(4'd8), M_RP = mk(4'd9), M_RZ = mk(4'd10),
                           M_ROC = mk(4'd11);
  localparam logic [W-1:0] M_ST = ~(M_RP | M_RZ | M_ROC);
  localparam logic [W-1:0] M_ONCE = ONCE & ~LOCK;

  logic quiet;
  assign quiet = (hw_set_i == '0) && (hw_clr_i == '0) && (hw_upd_i == '0);

  a_r6_hidden_zero: assert property (@(posedge clk) disable iff (!rst_n || !pg_rst_n)
    (rdata_o & (M_WO | M_RZ)) == '0);
  a_r9_const_view: assert property (@(posedge clk) disable iff (!rst_n || !pg_rst_n)
    sel_i |-> ((rdata_o & (M_ROC | M_RP)) == (INIT & (M_ROC | M_RP))));
  a_r14_idle_zero: assert property (@(posedge clk) disable iff (!rst_n || !pg_rst_n)
    !sel_i |-> (rdata_o == '0));
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n || !pg_rst_n)
    (sel_i && rd_i && !wr_i && quiet) |=> ((q & (M_RC | M_RCW)) == '0));
  a_r13_set_wins: assert property (@(posedge clk) disable iff (!rst_n || !pg_rst_n)
    (hw_set_i != '0) |=> ((q & $past(hw_set_i) & M_ST) == ($past(hw_set_i) & M_ST)));
  a_r1_ro_no_write: assert property (@(posedge clk) disable iff (!rst_n || !pg_rst_n)
    (sel_i && wr_i && quiet) |=> ((q & M_RO) == ($past(q) & M_RO)));
  a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!pg_rst_n)
    (!rst_n && $past(pg_rst_n)) |=> ((q & STICKY & M_ST) == ($past(q) & STICKY & M_ST)));
  a_r11_once_frozen: assert property (@(posedge clk) disable iff (!rst_n || !pg_rst_n)
    (sel_i && wr_i && quiet && ((used & M_ONCE) != '0)) |=>
      ((q & M_ONCE & $past(used)) == ($past(q) & M_ONCE & $past(used))));
endmodule

bind attr_csr attr_csr_chk #(
  .W(W), .ATTR(ATTR), .INIT(INIT), .STICKY(STICKY), .LOCK(LOCK), .ONCE(ONCE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pg_rst_n(pg_rst_n), .sel_i(sel_i), .rd_i(rd_i),
  .wr_i(wr_i), .hw_set_i(hw_set_i), .hw_clr_i(hw_clr_i), .hw_upd_i(hw_upd_i),
  .rdata_o(rdata_o), .q(q), .used(used)
);

// File: tb/sim_attr_csr.sv
`timescale 1ns/1ps
module sim_attr_csr;
  logic clk = 1'b0;
  logic rst_n = 1'b0, pg_rst_n = 1'b0;
  logic sel_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0, lock_i = 1'b0;
  logic [31:0] wdata_i = '0, hw_set_i = '0, hw_clr_i = '0, hw_upd_i = '0, hw_val_i = '0;
  logic [31:0] rdata_o;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  attr_csr u0 (
    .clk(clk), .rst_n(rst_n), .pg_rst_n(pg_rst_n), .sel_i(sel_i), .rd_i(rd_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .hw_set_i(hw_set_i),
    .hw_clr_i(hw_clr_i), .hw_upd_i(hw_upd_i), .hw_val_i(hw_val_i), .lock_i(lock_i)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic r, input logic w, input logic [31:0] wd,
                     input logic [31:0] st, input logic [31:0] cl, input logic [31:0] up,
                     input logic [31:0] vl, output logic [31:0] got);
    @(negedge clk);
    sel_i = s; rd_i = r; wr_i = w; wdata_i = wd;
    hw_set_i = st; hw_clr_i = cl; hw_upd_i = up; hw_val_i = vl;
    #1 got = rdata_o;
  endtask

  task automatic idle();
    logic [31:0] g;
    cyc(0, 0, 0, '0, '0, '0, '0, '0, g);
  endtask

  task automatic bwr(input logic [31:0] wd);
    logic [31:0] g;
    cyc(1, 0, 1, wd, '0, '0, '0, '0, g);
  endtask

  task automatic brd(output logic [31:0] got);
    cyc(1, 1, 0, '0, '0, '0, '0, '0, got);
  endtask

  task automatic hw(input logic [31:0] st, input logic [31:0] cl,
                    input logic [31:0] up, input logic [31:0] vl);
    logic [31:0] g;
    cyc(0, 0, 0, '0, st, cl, up, vl, g);
  endtask

  task automatic do_reset(input logic pg);
    idle();
    rst_n = 1'b0;
    pg_rst_n = pg ? 1'b0 : 1'b1;
    idle(); idle();
    rst_n = 1'b1; pg_rst_n = 1'b1;
    idle();
  endtask

  task automatic t_reset();
    logic [31:0] g;
    do_reset(1);
    brd(g); chk("R9 reset view", g, 32'h0000_0A00);
    idle(); #1 chk("R14 idle rdata", rdata_o, '0);
  endtask

  task automatic t_ro();
    logic [31:0] g;
    do_reset(1);
    bwr(32'h1); brd(g); chk("R1 write ignored", g & 32'h1, 32'h0);
    hw('0, '0, 32'h1, 32'h1); brd(g); chk("R1 hw load", g & 32'h1, 32'h1);
    bwr(32'h0); brd(g); chk("R1 zero write ignored", g & 32'h1, 32'h1);
  endtask

  task automatic t_rw();
    logic [31:0] g;
    do_reset(1);
    bwr(32'h0002_0002); brd(g); chk("R2 store ones", g & 32'h0002_0002, 32'h0002_0002);
    bwr(32'h0); brd(g); chk("R2 store zeros", g & 32'h0002_0002, 32'h0);
  endtask

  task automatic t_w1c_w0c();
    logic [31:0] g;
    do_reset(1);
    hw(32'hC, '0, '0, '0);
    bwr(32'h0); brd(g); chk("R3 zero kept / R4 zero clears", g & 32'hC, 32'h4);
    hw(32'h8, '0, '0, '0);
    bwr(32'hC); brd(g); chk("R3 one clears / R4 one kept", g & 32'hC, 32'h8);
  endtask

  task automatic t_w1s();
    logic [31:0] g;
    do_reset(1);
    bwr(32'h10); brd(g); chk("R5 one sets", g & 32'h10, 32'h10);
    bwr(32'h0);  brd(g); chk("R5 zero kept", g & 32'h10, 32'h10);
    hw('0, 32'h10, '0, '0); brd(g); chk("R5 hw clear", g & 32'h10, 32'h0);
  endtask

  task automatic t_hidden();
    logic [31:0] g;
    do_reset(1);
    bwr(32'h0000_0420); brd(g); chk("R6 write-only and reserved-zero", g & 32'h420, 32'h0);
  endtask

  task automatic t_readclr();
    logic [31:0] g;
    do_reset(1);
    hw(32'h40, '0, '0, '0);
    brd(g); chk("R7 read returns set value", g & 32'h40, 32'h40);
    brd(g); chk("R7 cleared after read", g & 32'h40, 32'h0);
    bwr(32'h100);
    brd(g); chk("R7 writable read-clear stores", g & 32'h100, 32'h100);
    brd(g); chk("R7 writable read-clear cleared", g & 32'h100, 32'h0);
  endtask

  task automatic t_readset();
    logic [31:0] g;
    do_reset(1);
    brd(g); chk("R8 first read old value", g & 32'h80, 32'h0);
    brd(g); chk("R8 set by read", g & 32'h80, 32'h80);
    bwr(32'h0); brd(g); chk("R8 zero write ignored", g & 32'h80, 32'h80);
    bwr(32'h80); brd(g); chk("R8 one write clears", g & 32'h80, 32'h0);
  endtask

  task automatic t_const();
    logic [31:0] g;
    do_reset(1);
    bwr(32'h0); hw(32'hFFFF_FFFF, '0, '0, '0); hw('0, 32'hFFFF_FFFF, '0, '0);
    brd(g); chk("R9 fixed bits hold", g & 32'h0000_0A00, 32'h0000_0A00);
  endtask

  task automatic t_sticky();
    logic [31:0] g;
    do_reset(1);
    bwr(32'h0000_1002); hw(32'h2000, '0, '0, '0);
    brd(g); chk("R10 before reset", g & 32'h3002, 32'h3002);
    do_reset(0);
    brd(g); chk("R10 after normal reset", g & 32'h3002, 32'h3000);
    do_reset(1);
    brd(g); chk("R10 after power-good reset", g & 32'h3002, 32'h0);
  endtask

  task automatic t_once();
    logic [31:0] g;
    do_reset(1);
    bwr(32'h0001_0000); brd(g); chk("R11 first write taken", g & 32'h10000, 32'h10000);
    bwr(32'h0); brd(g); chk("R11 second write ignored", g & 32'h10000, 32'h10000);
    do_reset(0);
    bwr(32'h0); bwr(32'h0001_0000); brd(g);
    chk("R11 rearmed by reset, first write only", g & 32'h10000, 32'h0);
  endtask

  task automatic t_lock();
    logic [31:0] g;
    do_reset(1);
    lock_i = 1'b1;
    bwr(32'h8000); brd(g); chk("R12 locked by input", g & 32'hC000, 32'h0);
    lock_i = 1'b0;
    bwr(32'h4000); bwr(32'hC000); brd(g); chk("R12 locked by key", g & 32'hC000, 32'h4000);
    bwr(32'h0); bwr(32'h8000); brd(g); chk("R12 unlocked after key clear", g & 32'hC000, 32'h8000);
  endtask

  task automatic t_prio();
    logic [31:0] g;
    do_reset(1);
    cyc(1, 0, 1, 32'h4, 32'h4, '0, '0, '0, g);
    brd(g); chk("R13 set beats write clear", g & 32'h4, 32'h4);
    hw(32'h10, 32'h10, '0, '0);
    brd(g); chk("R13 set beats hw clear", g & 32'h10, 32'h10);
    hw(32'h40, '0, '0, '0);
    cyc(1, 1, 0, '0, 32'h40, '0, '0, '0, g);
    brd(g); chk("R13 set beats read clear", g & 32'h40, 32'h40);
  endtask

  initial begin
    t_reset(); t_ro(); t_rw(); t_w1c_w0c(); t_w1s(); t_hidden(); t_readclr();
    t_readset(); t_const(); t_sticky(); t_once(); t_lock(); t_prio();
    idle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule